// File: doc/BRIEF.md
# Configuration File Header Skipper

This block sits on a byte stream that carries one configuration file at a time. It finds where the raw configuration data starts and passes only that data downstream. First it walks a fixed header made of four length-prefixed text fields. The first field sits at a fixed byte offset, and each field's length byte gives the position of the next field. Every byte up to the end of the last field is consumed and dropped. After the header the block searches for a sync pattern. From the pattern onward, every byte is forwarded unchanged until the end of the file. At the same moment the block reports the byte offset at which the forwarded data begins.

A static mode input selects one of two patterns. In two-byte mode the pattern is a 0xFF byte followed by a byte whose upper nibble is 0x3. The data starts after that second byte, so the pattern itself is not forwarded. In four-byte mode the pattern is four 0xFF bytes in a row, and the data starts at the first of them. The block holds the run of matched ones and replays it on the output before it accepts any more input. If a file ends before a pattern is found, the block pulses a miss flag. The byte index then restarts at zero for the next file.

Top module: `cfg_hdr_skip`

## Requirements
- R1: The first header length byte is at stream index 15. Exactly four fields are walked. A length byte L at index p puts the next length byte (or, after the fourth field, the first searched byte) at index p+L+3. Bytes inside fields never take part in the pattern search.
- R2: While scanning, whether in the header or in the search region, `in_ready` stays high, and each accepted byte is dropped without appearing on the output.
- R3: With `sync_mode`=0, a match is a searched byte 0xFF followed by a searched byte with bits [7:4] = 4'h3 (any lower nibble). The first forwarded byte is the one after the matching pair.
- R4: With `sync_mode`=1, a match is four consecutive searched bytes of 0xFF. Those four 0xFF bytes are forwarded first. `in_ready` stays low while they are replayed, and the input byte after the run is accepted only once the replay is finished.
- R5: In the cycle after the byte that completes a match is accepted, `start_found` pulses for one cycle. At the same time `start_offset` gives the stream index of the first forwarded byte: index of the second pattern byte + 1 in two-byte mode, or index of the first 0xFF in four-byte mode.
- R6: Bytes after the match are forwarded unchanged and in order, and `out_last` is set only on the file's final byte.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold. While forwarding, `in_ready` is low whenever the output register is full and not draining.
- R8: If a file's final byte (`in_last`) is accepted without a match, `sync_missing` pulses for one cycle and `start_found` does not. The stream index restarts at 0 for the next byte.
- R9: In two-byte mode, a match completed by the file's final byte pulses `start_found` with offset equal to the file length. Nothing is forwarded and `sync_missing` stays low.
- R10: After reset `out_valid`, `start_found` and `sync_missing` are low, `in_ready` is high, and the walker expects a length byte at index 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 0: two-byte sync, 1: four 0xFF preamble; held stable during a file |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a file |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Forwarded configuration byte |
| out_last | output | 1 | Final forwarded byte of the file |
| start_found | output | 1 | One-cycle pulse when the data start is found |
| start_offset | output | IDX_W | Stream index of the first forwarded byte |
| sync_missing | output | 1 | One-cycle pulse when a file ends without a match |

## Verification
The header fields hold 0xFF and 0x3x bytes and runs of 0xFF. A design that searched inside the fields, or too early, would lock onto one of these decoys and report an offset that is too small. The last field ends in 0xFF bytes just before a search region that opens with 0x35 or 0xFF. A pattern detector that kept history from header bytes would then match across the boundary. Near-miss patterns are sent: 0xFF followed by 0x43 or 0x2F, and runs of three ones. A design that compared the whole byte, or counted ones wrongly, would either miss the real pattern or fire early. Random output backpressure, files that end inside the header or on the matching byte, and the replay stall show up as lost, duplicated or mis-flagged bytes, or as a wrong miss pulse.

// File: rtl/cfghs_pkg.sv
package cfghs_pkg;

  typedef enum logic [1:0] {
    ST_SCAN   = 2'd0,
    ST_REPLAY = 2'd1,
    ST_PASS   = 2'd2
  } cfghs_state_e;

  localparam logic [7:0] ONES_BYTE = 8'hFF;

endpackage

// File: rtl/cfghs_field_walker.sv
module cfghs_field_walker #(
  parameter int IDX_W      = 24,
  parameter int HDR_OFS    = 15,
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_GAP  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic             search_en
);
  localparam int CNT_W = $clog2(NUM_FIELDS + 1);

  logic [CNT_W-1:0] left_q;
  logic [IDX_W-1:0] next_q;
  logic             on_len;

  assign on_len    = (left_q != '0) && (idx == next_q);
  assign search_en = (left_q == '0) && (idx >= next_q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      left_q <= CNT_W'(NUM_FIELDS);
      next_q <= IDX_W'(HDR_OFS);
    end else if (step && on_len) begin
      next_q <= idx + IDX_W'(data) + IDX_W'(FIELD_GAP);
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/cfghs_sync_detect.sv
module cfghs_sync_detect #(
  parameter int         PRE_LEN  = 4,
  parameter logic [3:0] SYNC_NIB = 4'h3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       step,
  input  logic       quad,
  input  logic [7:0] data,
  output logic       hit
);
  localparam int RUN_W = (PRE_LEN > 2) ? $clog2(PRE_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(PRE_LEN - 1);

  logic             prev_ff;
  logic [RUN_W-1:0] run_q;
  logic             is_ff;

  assign is_ff = (data == cfghs_pkg::ONES_BYTE);

  always_comb begin
    if (quad) hit = is_ff && (run_q == RUN_TOP);
    else      hit = prev_ff && (data[7:4] == SYNC_NIB);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prev_ff <= 1'b0;
      run_q   <= '0;
    end else if (step) begin
      prev_ff <= is_ff;
      if (!is_ff)                run_q <= '0;
      else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfghs_replay_buf.sv
module cfghs_replay_buf #(
  parameter int PRE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_last,
  input  logic pop,
  output logic active,
  output logic final_beat,
  output logic ends_file
);
  localparam int CNT_W = $clog2(PRE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             last_q;

  assign active     = (cnt_q != '0);
  assign final_beat = (cnt_q == CNT_W'(1));
  assign ends_file  = last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= CNT_W'(PRE_LEN);
      last_q <= load_last;
    end else if (pop && active) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cfg_hdr_skip.sv
module cfg_hdr_skip #(
  parameter int         IDX_W      = 24,
  parameter int         HDR_OFS    = 15,
  parameter int         NUM_FIELDS = 4,
  parameter int         FIELD_GAP  = 3,
  parameter int         PRE_LEN    = 4,
  parameter logic [3:0] SYNC_NIB   = 4'h3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             start_found,
  output logic [IDX_W-1:0] start_offset,
  output logic             sync_missing
);
  import cfghs_pkg::*;

  localparam logic [IDX_W-1:0] BACK_STEP = IDX_W'(PRE_LEN - 1);
  localparam logic [IDX_W-1:0] ONE_STEP  = IDX_W'(1);

  cfghs_state_e     st_q;
  logic [IDX_W-1:0] idx_q;
  logic             out_free, accept, scan_step, srch_step, matched;
  logic             file_end, rep_pop, pass_load;
  logic             search_en, hit;
  logic             rep_active, rep_final, rep_ends;

  assign out_free = !out_valid || out_ready;

  always_comb begin
    case (st_q)
      ST_SCAN: in_ready = 1'b1;
      ST_PASS: in_ready = out_free;
      default: in_ready = 1'b0;
    endcase
  end

  assign accept    = in_valid && in_ready;
  assign scan_step = accept && (st_q == ST_SCAN);
  assign srch_step = scan_step && search_en;
  assign matched   = srch_step && hit;
  assign file_end  = accept && in_last;
  assign rep_pop   = (st_q == ST_REPLAY) && out_free && rep_active;
  assign pass_load = (st_q == ST_PASS) && accept;

  cfghs_field_walker #(
    .IDX_W(IDX_W), .HDR_OFS(HDR_OFS), .NUM_FIELDS(NUM_FIELDS), .FIELD_GAP(FIELD_GAP)
  ) u_walk (
    .clk(clk), .rst(rst), .clear(file_end), .step(scan_step),
    .idx(idx_q), .data(in_data), .search_en(search_en)
  );

  cfghs_sync_detect #(
    .PRE_LEN(PRE_LEN), .SYNC_NIB(SYNC_NIB)
  ) u_sync (
    .clk(clk), .rst(rst), .clear(file_end), .step(srch_step),
    .quad(sync_mode), .data(in_data), .hit(hit)
  );

  cfghs_replay_buf #(
    .PRE_LEN(PRE_LEN)
  ) u_replay (
    .clk(clk), .rst(rst), .load(matched && sync_mode), .load_last(in_last),
    .pop(rep_pop), .active(rep_active), .final_beat(rep_final), .ends_file(rep_ends)
  );

  // stream byte index, restarted after each file
  always_ff @(posedge clk) begin
    if (rst)           idx_q <= '0;
    else if (file_end) idx_q <= '0;
    else if (accept)   idx_q <= idx_q + ONE_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_SCAN;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_last     <= 1'b0;
      start_found  <= 1'b0;
      start_offset <= '0;
      sync_missing <= 1'b0;
    end else begin
      start_found  <= 1'b0;
      sync_missing <= 1'b0;

      if (pass_load) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_last  <= in_last;
      end else if (rep_pop) begin
        out_valid <= 1'b1;
        out_data  <= ONES_BYTE;
        out_last  <= rep_final && rep_ends;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end

      case (st_q)
        ST_SCAN: begin
          if (matched) begin
            start_found  <= 1'b1;
            start_offset <= sync_mode ? (idx_q - BACK_STEP) : (idx_q + ONE_STEP);
            if (sync_mode)    st_q <= ST_REPLAY;
            else if (!in_last) st_q <= ST_PASS;
          end else if (scan_step && in_last) begin
            sync_missing <= 1'b1;
          end
        end
        ST_REPLAY: begin
          if (rep_pop && rep_final) st_q <= rep_ends ? ST_SCAN : ST_PASS;
        end
        ST_PASS: begin
          if (file_end) st_q <= ST_SCAN;
        end
        default: st_q <= ST_SCAN;
      endcase
    end
  end
endmodule

// File: rtl/cfg_hdr_skip_chk.sv
module cfg_hdr_skip_chk (
  input logic       clk,
  input logic       rst,
  input logic       sync_mode,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       start_found,
  input logic       sync_missing
);
  logic pay_open;

  always_ff @(posedge clk) begin
    if (rst)                                  pay_open <= 1'b0;
    else if (start_found)                     pay_open <= 1'b1;
    else if (out_valid && out_ready && out_last) pay_open <= 1'b0;
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R8
  found_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    start_found |-> !sync_missing);

  // R4
  replay_stall_chk: assert property (@(posedge clk) disable iff (rst)
    start_found && sync_mode |-> !in_ready);

  // R2
  no_early_out_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> pay_open);

  // R2
  scan_ready_chk: assert property (@(posedge clk) disable iff (rst)
    sync_missing |-> in_ready);
endmodule

bind cfg_hdr_skip cfg_hdr_skip_chk u_chk (
  .clk(clk), .rst(rst), .sync_mode(sync_mode), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .start_found(start_found), .sync_missing(sync_missing)
);

// File: tb/cfg_hdr_skip_tb.sv
`timescale 1ns/1ps
module cfg_hdr_skip_tb;
  localparam int IDX_W = 24;
  localparam int HDR   = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_mode = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic out_last;
  logic start_found;
  logic [IDX_W-1:0] start_offset;
  logic sync_missing;

  always #2.5 clk = ~clk;

  cfg_hdr_skip #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .start_found(start_found), .start_offset(start_offset),
    .sync_missing(sync_missing)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] fbuf [256];
  int stall [256];
  logic [7:0] got [256];
  int got_n, last_n, last_pos, found_n, miss_n, got_off;
  bit bp_on = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // output-side backpressure
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_on ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // collector, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready) begin
        got[got_n] = out_data;
        if (out_last) begin last_n++; last_pos = got_n; end
        got_n++;
      end
      if (start_found) begin found_n++; got_off = int'(start_offset); end
      if (sync_missing) miss_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // writes four fields; header filler carries decoys; returns search start
  task automatic build_hdr(input int l0, input int l1, input int l2, input int l3,
                           output int pos);
    int lens [4];
    lens = '{l0, l1, l2, l3};
    for (int k = 0; k < HDR; k++) fbuf[k] = (k % 3 == 0) ? 8'h35 : 8'hFF;
    pos = HDR;
    for (int f = 0; f < 4; f++) begin
      fbuf[pos] = 8'(lens[f]);
      for (int k = 1; k <= lens[f] + 2; k++) fbuf[pos + k] = (k % 2 == 1) ? 8'hFF : 8'h3A;
      pos = pos + lens[f] + 3;
      fbuf[pos - 1] = 8'hFF;
    end
  endtask

  function automatic void model(input int len, input bit quad,
                                output bit found, output int start);
    int pos = HDR;
    found = 1'b0;
    start = len;
    for (int f = 0; f < 4; f++) begin
      if (pos >= len) return;
      pos = pos + int'(fbuf[pos]) + 3;
    end
    if (quad) begin
      for (int i = pos + 3; i < len && !found; i++)
        if (fbuf[i] == 8'hFF && fbuf[i-1] == 8'hFF && fbuf[i-2] == 8'hFF && fbuf[i-3] == 8'hFF) begin
          found = 1'b1; start = i - 3;
        end
    end else begin
      for (int i = pos + 1; i < len && !found; i++)
        if (fbuf[i-1] == 8'hFF && fbuf[i][7:4] == 4'h3) begin
          found = 1'b1; start = i + 1;
        end
    end
  endfunction

  task automatic drive_file(input int len);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = fbuf[i]; in_last = (i == len - 1);
      stall[i] = 0;
      @(negedge clk);
      while (!in_ready) begin stall[i]++; @(negedge clk); end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_file(input string name, input int len, input bit quad, input bit bp);
    bit ef; int es, match_i, st_sum, plen, bad;
    got_n = 0; last_n = 0; last_pos = -1; found_n = 0; miss_n = 0; got_off = -1;
    sync_mode = quad; bp_on = bp;
    drive_file(len);
    repeat (120) @(posedge clk);
    bp_on = 1'b0;
    repeat (10) @(posedge clk);
    model(len, quad, ef, es);
    $display("case %s: found=%0d start=%0d", name, ef, es);
    chk(found_n == int'(ef), quad ? "R4" : "R3", "match pulses", found_n, int'(ef));
    chk(miss_n == int'(!ef), "R8", "miss pulses", miss_n, int'(!ef));
    if (ef) chk(got_off == es, "R1 R5", "start offset", got_off, es);
    match_i = ef ? (quad ? es + 3 : es - 1) : len - 1;
    st_sum = 0;
    for (int i = 0; i <= match_i; i++) st_sum += stall[i];
    chk(st_sum == 0, "R2", "scan stalls", st_sum, 0);
    plen = ef ? len - es : 0;
    chk(got_n == plen, bp ? "R6 R7" : "R6", "payload bytes", got_n, plen);
    bad = -1;
    for (int i = 0; i < got_n && i < plen; i++)
      if (bad < 0 && got[i] != fbuf[es + i]) bad = i;
    if (plen > 0) begin
      chk(bad < 0, bp ? "R6 R7" : "R6", "first bad byte index", bad, -1);
      chk(last_n == 1 && last_pos == plen - 1, "R6", "last flag position", last_pos, plen - 1);
    end else begin
      chk(last_n == 0, "R9", "last flags with empty payload", last_n, 0);
    end
    if (quad && ef && !bp && match_i + 1 < len)
      chk(stall[match_i + 1] == 4, "R4 R7", "stall during replay", stall[match_i + 1], 4);
  endtask

  task automatic load_body(input int pos, input logic [7:0] b [], output int len);
    for (int i = 0; i < b.size(); i++) fbuf[pos + i] = b[i];
    len = pos + b.size();
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R10", "out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R10", "in_ready", in_ready, 1);
    chk(start_found == 1'b0 && sync_missing == 1'b0, "R10", "pulses", start_found, 0);
  endtask

  task automatic t_two_byte_basic();
    int p, n;
    build_hdr(2, 1, 0, 3, p);
    load_body(p, '{8'h35, 8'h00, 8'hFF, 8'h12, 8'hFF, 8'h43, 8'hFF, 8'hFF, 8'h3F,
                   8'hA5, 8'h5A, 8'h00, 8'hFF, 8'hC3, 8'h3F}, n);
    run_file("R3 two-byte decoys", n, 1'b0, 1'b0);
  endtask

  task automatic t_two_byte_bp();
    int p, n;
    build_hdr(5, 0, 7, 1, p);
    fbuf[p] = 8'hFF; fbuf[p + 1] = 8'h30;
    for (int i = 0; i < 20; i++) fbuf[p + 2 + i] = 8'(i * 37 + 3);
    n = p + 22;
    run_file("R7 two-byte backpressure", n, 1'b0, 1'b1);
  endtask

  task automatic t_quad_basic();
    int p, n;
    build_hdr(1, 1, 1, 1, p);
    fbuf[p - 3] = 8'hFF; fbuf[p - 2] = 8'hFF;
    load_body(p, '{8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h12, 8'hFF, 8'hFF, 8'hFF,
                   8'hFF, 8'h9A, 8'hBC, 8'hDE}, n);
    run_file("R4 four-byte", n, 1'b1, 1'b0);
  endtask

  task automatic t_quad_bp();
    int p, n;
    build_hdr(4, 2, 0, 6, p);
    load_body(p, '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h11, 8'h22, 8'h33, 8'h44,
                   8'h55, 8'h66, 8'h77}, n);
    run_file("R4 four-byte backpressure", n, 1'b1, 1'b1);
  endtask

  task automatic t_miss();
    int p, n;
    build_hdr(3, 3, 3, 3, p);
    load_body(p, '{8'hFF, 8'h40, 8'hFF, 8'h2F, 8'h00, 8'h35}, n);
    run_file("R8 two-byte miss", n, 1'b0, 1'b0);
    build_hdr(0, 2, 1, 0, p);
    load_body(p, '{8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF}, n);
    run_file("R8 four-byte miss", n, 1'b1, 1'b0);
    build_hdr(2, 2, 2, 2, p);
    run_file("R8 cut in header", 20, 1'b0, 1'b0);
  endtask

  task automatic t_match_on_last();
    int p, n;
    build_hdr(1, 0, 2, 0, p);
    load_body(p, '{8'h00, 8'hFF, 8'h31}, n);
    run_file("R9 match on final byte", n, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_two_byte_basic();
    t_two_byte_bp();
    t_quad_basic();
    t_quad_bp();
    t_miss();
    t_match_on_last();
    t_two_byte_basic();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule